// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer with Watchdog Reset

A bank of 32-bit down-counters sits behind a small synchronous register bus. Each channel has a live count and a reload value. One shared control word holds, for every channel, a run bit, a periodic bit and a bit that chooses what the channel counts: every core clock cycle, or only the cycles in which the 25 MHz reference strobe is high. When a channel counts from 1 down to 0 it sets its bit in an interrupt cause word. A periodic channel then copies its reload value back into the count and keeps running. A one-shot channel holds at zero. A mask word gates each cause bit onto its interrupt line.

One channel (index 2 by default) also acts as a watchdog. Its expiry asserts a sticky reset-out line, but only when a separate reset-out unmask bit is set. Software that does not refresh the watchdog count in time causes a system reset. A channel loaded with all ones and run periodically gives a free-running time base: the elapsed ticks are all-ones minus the count.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is zero and `rst_out_o` is low.
- R2: A channel whose run bit is set decrements its count by one on each count tick. A channel whose run bit is clear holds its count. A channel run periodically from 0xFFFFFFFF shows elapsed ticks as 0xFFFFFFFF minus its count.
- R3: Expiry is a tick that takes an enabled count from 1 to 0. It sets that channel's cause bit on the same clock edge. With the periodic bit clear, the count stays at 0 afterwards.
- R4: With the periodic bit set, an expiry loads the channel's reload value into the count on the same edge, and counting continues from it.
- R5: With the reference-select bit set, a channel ticks only on cycles where `ref_tick_i` is high. With the bit clear, it ticks on every clock.
- R6: Writing the cause word (0x04) clears each bit written 0 and leaves each bit written 1 unchanged. An expiry on the same edge as a clearing write leaves that bit set.
- R7: `irq_o[n]` is high only while cause bit n and mask bit n (mask word 0x08) are both set.
- R8: An expiry of the watchdog channel sets `rst_out_o` when bit 0 of the reset-out unmask word (0x0C) is set. Expiries of other channels, or of the watchdog channel while unmasked is clear, leave it low. Once set, it stays high until `rst_ni` is asserted.
- R9: A bus write to a count register takes effect on the next edge, even while the channel runs. If it lands on the edge of an expiry, the written value replaces the reload or zero, and the cause bit is still set.
- R10: Register map, by byte address: control word at 0x00, with bits 4n, 4n+1 and 4n+2 as run, periodic and reference-select for channel n; count n at 0x10+8n; reload n at 0x14+8n. Unused control, cause and mask bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle enable strobe at the 25 MHz reference rate |
| bus_addr_i | input | AW | Byte address of register |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for `bus_addr_i`, combinational |
| irq_o | output | N_CH | Masked per-channel interrupt |
| rst_out_o | output | 1 | Watchdog reset request, sticky |

## Verification
A bus write can land on the same clock edge as a channel's expiry in two ways: a write that clears the cause bit, and a write to the count register. The bench provokes each case by loading a count of 3 and starting the channel. It then waits one cycle so that the write's capture edge is exactly the third count edge. The expected outcomes are fixed by the requirements: the cause bit survives the clearing write, and the written value replaces the periodic reload while the cause bit is still raised. Both are read back through the bus on the following cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CH_FIELD_W    = 4;
  localparam int EN_BIT        = 0;
  localparam int AUTO_BIT      = 1;
  localparam int REF_BIT       = 2;

  localparam int ADDR_CTRL     = 'h00;
  localparam int ADDR_CAUSE    = 'h04;
  localparam int ADDR_MASK     = 'h08;
  localparam int ADDR_WDMASK   = 'h0C;
  localparam int ADDR_CNT_BASE = 'h10;
  localparam int ADDR_RLD_BASE = 'h14;
  localparam int CH_STRIDE     = 8;

  typedef struct packed {
    logic ref_sel;
    logic auto_rld;
    logic en;
  } chan_ctrl_t;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          auto_i,
  input  logic          tick_i,
  input  logic          cnt_we_i,
  input  logic          rld_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic          expire_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q, rld_q;
  logic          step;

  assign step     = en_i && tick_i;
  assign expire_o = step && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;                 // bus write beats reload
    end else if (expire_o) begin
      cnt_q <= auto_i ? rld_q : '0;
    end else if (step && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rld_q <= '0;
    else if (rld_we_i) rld_q <= wdata_i;
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && !en_i) |=> $stable(cnt_q));
  // R9
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(wdata_i));
  // R3
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !auto_i && !cnt_we_i) |=> cnt_q == '0);
  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && auto_i && !cnt_we_i) |=> cnt_q == $past(rld_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int N_CH   = 4,
  parameter int WDT_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] expire_i,
  input  logic            cause_we_i,
  input  logic            mask_we_i,
  input  logic            wdm_we_i,
  input  logic [N_CH-1:0] wdata_i,
  output logic [N_CH-1:0] cause_o,
  output logic [N_CH-1:0] mask_o,
  output logic            wdm_o,
  output logic [N_CH-1:0] irq_o,
  output logic            rst_out_o
);
  logic [N_CH-1:0] cause_q, mask_q;
  logic            wdm_q, rst_out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q   <= '0;
      mask_q    <= '0;
      wdm_q     <= 1'b0;
      rst_out_q <= 1'b0;
    end else begin
      // write-0-to-clear; a fresh expiry wins over the clear
      cause_q <= (cause_we_i ? (cause_q & wdata_i) : cause_q) | expire_i;
      if (mask_we_i) mask_q <= wdata_i;
      if (wdm_we_i)  wdm_q  <= wdata_i[0];
      if (expire_i[WDT_CH] && wdm_q) rst_out_q <= 1'b1;
    end
  end

  assign cause_o   = cause_q;
  assign mask_o    = mask_q;
  assign wdm_o     = wdm_q;
  assign irq_o     = cause_q & mask_q;
  assign rst_out_o = rst_out_q;

  // R6
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_we_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  // R3
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|expire_i) |=> ((cause_q & $past(expire_i)) == $past(expire_i)));
  // R8
  rst_out_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_out_q |=> rst_out_q);
  // R8
  rst_out_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_out_q && !(expire_i[WDT_CH] && wdm_q)) |=> !rst_out_q);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int WDT_CH = 2,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_tick_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_we_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic [N_CH-1:0] irq_o,
  output logic            rst_out_o
);
  chan_ctrl_t      ctrl_q [N_CH];
  logic [N_CH-1:0] cnt_hit, rld_hit, expire, tick;
  logic [DW-1:0]   cnt_v [N_CH];
  logic [DW-1:0]   rld_v [N_CH];
  logic [N_CH-1:0] cause, mask;
  logic            wdm;
  logic [DW-1:0]   ctrl_rd;
  logic            ctrl_hit, cause_hit, mask_hit, wdm_hit;

  assign ctrl_hit  = bus_addr_i == AW'(ADDR_CTRL);
  assign cause_hit = bus_addr_i == AW'(ADDR_CAUSE);
  assign mask_hit  = bus_addr_i == AW'(ADDR_MASK);
  assign wdm_hit   = bus_addr_i == AW'(ADDR_WDMASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_CH; k++) ctrl_q[k] <= '0;
    end else if (bus_we_i && ctrl_hit) begin
      for (int k = 0; k < N_CH; k++) begin
        ctrl_q[k].en       <= bus_wdata_i[k*CH_FIELD_W + EN_BIT];
        ctrl_q[k].auto_rld <= bus_wdata_i[k*CH_FIELD_W + AUTO_BIT];
        ctrl_q[k].ref_sel  <= bus_wdata_i[k*CH_FIELD_W + REF_BIT];
      end
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign cnt_hit[k] = bus_addr_i == AW'(ADDR_CNT_BASE + k*CH_STRIDE);
    assign rld_hit[k] = bus_addr_i == AW'(ADDR_RLD_BASE + k*CH_STRIDE);
    assign tick[k]    = ctrl_q[k].ref_sel ? ref_tick_i : 1'b1;

    tmr_chan #(.DW(DW)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (ctrl_q[k].en),
      .auto_i   (ctrl_q[k].auto_rld),
      .tick_i   (tick[k]),
      .cnt_we_i (bus_we_i && cnt_hit[k]),
      .rld_we_i (bus_we_i && rld_hit[k]),
      .wdata_i  (bus_wdata_i),
      .cnt_o    (cnt_v[k]),
      .rld_o    (rld_v[k]),
      .expire_o (expire[k])
    );
  end

  tmr_irq #(.N_CH(N_CH), .WDT_CH(WDT_CH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire),
    .cause_we_i (bus_we_i && cause_hit),
    .mask_we_i  (bus_we_i && mask_hit),
    .wdm_we_i   (bus_we_i && wdm_hit),
    .wdata_i    (bus_wdata_i[N_CH-1:0]),
    .cause_o    (cause),
    .mask_o     (mask),
    .wdm_o      (wdm),
    .irq_o      (irq_o),
    .rst_out_o  (rst_out_o)
  );

  always_comb begin
    ctrl_rd = '0;
    for (int k = 0; k < N_CH; k++) ctrl_rd[k*CH_FIELD_W +: 3] = ctrl_q[k];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (ctrl_hit)  bus_rdata_o = ctrl_rd;
    if (cause_hit) bus_rdata_o = DW'(cause);
    if (mask_hit)  bus_rdata_o = DW'(mask);
    if (wdm_hit)   bus_rdata_o = DW'(wdm);
    for (int k = 0; k < N_CH; k++) begin
      if (cnt_hit[k]) bus_rdata_o = cnt_v[k];
      if (rld_hit[k]) bus_rdata_o = rld_v[k];
    end
  end
endmodule

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        rst_out;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tmr_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .rst_out_o(rst_out)
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_CAUSE = 8'h04, A_MASK = 8'h08, A_WDM = 8'h0C;
  function automatic logic [7:0] a_cnt(int n); return 8'(8'h10 + 8*n); endfunction
  function automatic logic [7:0] a_rld(int n); return 8'(8'h14 + 8*n); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #0.1; d = rdata;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_ni = 1'b0; we = 1'b0; ref_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_CAUSE, v); chk("R1 cause", v, 0);
    rd(A_MASK, v);  chk("R1 mask", v, 0);
    rd(A_WDM, v);   chk("R1 wdmask", v, 0);
    for (int n = 0; n < 4; n++) begin
      rd(a_cnt(n), v); chk("R1 count", v, 0);
      rd(a_rld(n), v); chk("R1 reload", v, 0);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rst_out", 32'(rst_out), 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R10 ctrl bits", v, 32'h0000_7777);
    wr(A_CTRL, 0);
    for (int n = 0; n < 4; n++) begin
      wr(a_cnt(n), 32'h100 + 32'(n));
      wr(a_rld(n), 32'h200 + 32'(n));
    end
    for (int n = 0; n < 4; n++) begin
      rd(a_cnt(n), v); chk("R10 count addr", v, 32'h100 + 32'(n));
      rd(a_rld(n), v); chk("R10 reload addr", v, 32'h200 + 32'(n));
    end
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, v); chk("R10 mask width", v, 32'hF);
    wr(A_CAUSE, 32'hFFFF_FFFF); rd(A_CAUSE, v); chk("R6 write 1 no set", v, 0);
    wr(A_MASK, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(a_cnt(0), 7); wr(A_CTRL, 0);
    repeat (4) @(negedge clk);
    rd(a_cnt(0), v); chk("R2 disabled hold", v, 7);
    wr(a_cnt(0), 5); wr(A_CTRL, 32'h1);
    rd(a_cnt(0), v); chk("R2 start value", v, 5);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk); rd(a_cnt(0), v); chk("R2 decrement", v, 32'(5 - i));
      rd(A_CAUSE, v); chk("R3 no early cause", v, 0);
    end
    @(negedge clk);
    rd(a_cnt(0), v); chk("R3 reaches zero", v, 0);
    rd(A_CAUSE, v);  chk("R3 cause on expiry", v, 32'h1);
    repeat (3) @(negedge clk);
    rd(a_cnt(0), v); chk("R3 one-shot stays zero", v, 0);
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(a_rld(1), 2); wr(a_cnt(1), 3); wr(A_CTRL, 32'h30);
    rd(a_cnt(1), v); chk("R4 start", v, 3);
    @(negedge clk); rd(a_cnt(1), v); chk("R4 count", v, 2);
    @(negedge clk); rd(a_cnt(1), v); chk("R4 count", v, 1);
    @(negedge clk); rd(a_cnt(1), v); chk("R4 reload", v, 2);
    rd(A_CAUSE, v); chk("R3 periodic cause", v, 32'h2);
    @(negedge clk); rd(a_cnt(1), v); chk("R4 count", v, 1);
    @(negedge clk); rd(a_cnt(1), v); chk("R4 second reload", v, 2);
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
    wr(a_rld(1), 32'hFFFF_FFFF); wr(a_cnt(1), 32'hFFFF_FFFF); wr(A_CTRL, 32'h30);
    repeat (10) @(negedge clk);
    rd(a_cnt(1), v); chk("R2 elapsed time", 32'hFFFF_FFFF - v, 10);
    wr(A_CTRL, 0);
  endtask

  task automatic t_refclk;
    logic [31:0] v;
    wr(a_cnt(3), 10); wr(A_CTRL, 32'h5000);
    repeat (5) @(negedge clk);
    rd(a_cnt(3), v); chk("R5 no ref tick no count", v, 10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
    rd(a_cnt(3), v); chk("R5 counts ref ticks", v, 7);
    wr(A_CTRL, 0);
  endtask

  task automatic t_cause_mask;
    logic [31:0] v;
    wr(a_cnt(0), 1); wr(A_CTRL, 32'h1);
    @(negedge clk);
    rd(A_CAUSE, v); chk("R3 cause bit0", v, 32'h1);
    chk("R7 masked irq low", 32'(irq), 0);
    wr(A_MASK, 32'h1);
    chk("R7 unmasked irq", 32'(irq), 32'h1);
    wr(A_CAUSE, 32'hFFFF_FFFF); rd(A_CAUSE, v); chk("R6 write 1 keeps", v, 32'h1);
    wr(A_CAUSE, 32'hFFFF_FFFE); rd(A_CAUSE, v); chk("R6 write 0 clears", v, 0);
    chk("R7 irq drops", 32'(irq), 0);
    wr(A_CTRL, 0); wr(A_MASK, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(a_cnt(0), 3); wr(A_CTRL, 32'h1);
    @(negedge clk);
    wr(A_CAUSE, 0);                  // captured on the expiry edge
    rd(A_CAUSE, v); chk("R6 expiry beats clear", v, 32'h1);
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
    wr(a_rld(0), 9); wr(a_cnt(0), 3); wr(A_CTRL, 32'h3);
    @(negedge clk);
    wr(a_cnt(0), 32'h40);            // captured on the expiry edge
    rd(a_cnt(0), v); chk("R9 write beats reload", v, 32'h40);
    rd(A_CAUSE, v);  chk("R9 cause still set", v, 32'h1);
    @(negedge clk);
    rd(a_cnt(0), v); chk("R9 runs from written value", v, 32'h3F);
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
  endtask

  task automatic t_wdog;
    logic [31:0] v;
    wr(a_cnt(2), 2); wr(A_CTRL, 32'h100);
    repeat (2) @(negedge clk);
    rd(A_CAUSE, v); chk("R8 wdog cause", v, 32'h4);
    chk("R8 closed unmask no reset", 32'(rst_out), 0);
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
    wr(A_WDM, 1);
    wr(a_cnt(0), 1); wr(A_CTRL, 32'h1);
    @(negedge clk);
    chk("R8 other channel no reset", 32'(rst_out), 0);
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
    wr(a_cnt(2), 2); wr(A_CTRL, 32'h100);
    @(negedge clk);
    chk("R8 not before expiry", 32'(rst_out), 0);
    @(negedge clk);
    chk("R8 reset-out asserted", 32'(rst_out), 1);
    wr(A_CAUSE, 0); wr(A_CTRL, 0);
    repeat (3) @(negedge clk);
    chk("R8 reset-out sticky", 32'(rst_out), 1);
    do_reset();
    chk("R8 cleared by reset", 32'(rst_out), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_regmap();
    t_oneshot();
    t_periodic();
    t_refclk();
    t_cause_mask();
    t_collide();
    t_wdog();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule